// File: doc/BRIEF.md
# Prioritized Interrupt Encoder with Vector Acknowledge

This block gathers interrupt requests from four classes of source and presents the most urgent one to a processor as a 3-bit active-low priority code. The classes are seven local request lines, seven backplane request levels, six internal status events and eight interprocessor switches. Each local line has its own configuration: a priority level, edge or level sensing, active polarity, and whether the controller itself returns the vector for it. Each of the other three classes shares one programmable priority level. Priority level 0 masks a source.

When the processor runs an acknowledge cycle for a level, the block picks the pending source at that level. If several sources share the level, the lowest source index wins. One cycle later the block returns a status/ID vector, or it flags that the vector must come from elsewhere. Latched requests from edge-sensed lines and status events are cleared by their own acknowledge. Level-sensed requests follow their inputs.

Configuration is written through a small write-only port. Addresses 0 to 6 select local lines 0 to 6. Address 8 holds the backplane level, address 9 the status-event level and address 10 the switch level. For a local line the data bits are [2:0] level, [3] edge mode, [4] polarity (1 = active-high/rising, 0 = active-low/falling) and [5] vector supply. For the shared registers only bits [2:0] are used. Source indices are: local line i = i, backplane level i = 7+i, event i = 14+i, switch i = 20+i.

Top module: `irq_prio_ctl`

## Requirements
- R1: While and after reset, ipl_n_o is 3'b111 and vec_vld_o is 0. All levels reset to 0, all local lines reset to level sensing with polarity 1 and vector supply off.
- R2: ipl_n_o equals the bitwise inverse of the highest level among pending sources, with level 0 never counting. A level-sensed input change shows on ipl_n_o after one clock edge. A configuration write shows after two.
- R3: Polarity bit 1 makes a local line active when high (rising edge in edge mode). Polarity bit 0 makes it active when low (falling edge).
- R4: An edge-sensed local line latches a pending request on its active transition, two edges before ipl_n_o shows it. The request stays after the input returns and clears when that line is acknowledged.
- R5: A level-sensed local line is pending exactly while its input is active, and an acknowledge does not clear it.
- R6: Backplane level i is pending while bp_irq_i[i] is high, at the shared backplane level. Its acknowledge returns vec_ext_o=1 and vec_o=0.
- R7: A status event input high in any cycle latches a request that stays until that event is acknowledged. Its acknowledge returns vec_o = VEC_BASE + 14 + i.
- R8: Switch i is pending while ipc_sw_i[i] is high, at the shared switch level. Its acknowledge returns vec_o = VEC_BASE + 20 + i and vec_ext_o=0.
- R9: A one-cycle iack_i with iack_lvl_i gives vec_vld_o=1 for one cycle on the following edge. The response is for the pending source at that level with the lowest index.
- R10: For a local line with vector supply set, the acknowledge returns vec_o = VEC_BASE + line and vec_ext_o=0. With it clear, it returns vec_o=0 and vec_ext_o=1.
- R11: An acknowledge at a level with no pending source returns vec_o = SPUR_VEC and vec_ext_o=0.
- R12: A configuration write to a local line clears that line's latched edge request.
- R13: If a status event input is high in the same cycle as the acknowledge that clears it, the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 6 | Configuration write data |
| loc_irq_i | input | 7 | Local request lines |
| bp_irq_i | input | 7 | Backplane request levels, active high |
| evt_i | input | 6 | Status event inputs, active high |
| ipc_sw_i | input | 8 | Interprocessor switch states |
| iack_i | input | 1 | One-cycle acknowledge strobe |
| iack_lvl_i | input | 3 | Level being acknowledged |
| ipl_n_o | output | 3 | Encoded priority, active low |
| vec_vld_o | output | 1 | Acknowledge response valid |
| vec_o | output | 8 | Status/ID vector |
| vec_ext_o | output | 1 | Vector must come from an external source |

## Verification
The hardest case to reach is a status event arriving in the very cycle its own acknowledge clears it, because the set and the clear then meet at one register edge. The bench first latches an event. It then raises the event input again on the same falling edge that starts the acknowledge, and checks that a second acknowledge still finds the request. Ties are reached by pending a backplane level and a switch at the same programmed level, then releasing the winner and acknowledging again.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int LVL_W = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  // Per-line configuration, packed to match write data bits [5:0]
  typedef struct packed {
    logic vs;      // controller supplies the vector
    logic pol;     // 1: active high / rising, 0: active low / falling
    logic edge_m;  // 1: edge sensed, 0: level sensed
    lvl_t lvl;     // priority level, 0 masks
  } loc_cfg_t;

  localparam int CFG_W = $bits(loc_cfg_t);

  localparam loc_cfg_t LOC_CFG_RST = '{vs: 1'b0, pol: 1'b1, edge_m: 1'b0, lvl: '0};

  localparam logic [3:0] ADR_BP  = 4'd8;
  localparam logic [3:0] ADR_EVT = 4'd9;
  localparam logic [3:0] ADR_IPC = 4'd10;

endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_prio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_i,
  input  loc_cfg_t cfg_i,
  input  logic     cfg_wr_i,
  input  logic     ack_clr_i,
  output logic     pend_o
);

  logic act;
  logic act_q, act_d;
  logic lat_q, lat_d;
  logic edge_set;

  always_comb begin
    act      = cfg_i.pol ? in_i : ~in_i;
    edge_set = act & ~act_q;
    act_d    = act;
    if (cfg_wr_i)
      lat_d = 1'b0;
    else
      lat_d = cfg_i.edge_m & ((lat_q & ~ack_clr_i) | edge_set);
    pend_o   = cfg_i.edge_m ? lat_q : act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      act_q <= act_d;
      lat_q <= lat_d;
    end
  end

endmodule

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick
  import irq_prio_pkg::*;
#(
  parameter int N  = 28,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]            pend_i,
  input  logic [N-1:0][LVL_W-1:0] lvl_i,
  input  lvl_t                    req_i,
  output logic                    hit_o,
  output logic [IW-1:0]           idx_o
);

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    // descending scan: the lowest matching index is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i] && (lvl_i[i] == req_i) && (req_i != '0)) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_top_enc.sv
module irq_top_enc
  import irq_prio_pkg::*;
#(
  parameter int N = 28
) (
  input  logic [N-1:0]            pend_i,
  input  logic [N-1:0][LVL_W-1:0] lvl_i,
  output lvl_t                    top_o
);

  always_comb begin
    top_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && (lvl_i[i] > top_o))
        top_o = lvl_i[i];
    end
  end

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
#(
  parameter int         N_LOC    = 7,
  parameter int         N_BP     = 7,
  parameter int         N_EVT    = 6,
  parameter int         N_IPC    = 8,
  parameter int         VW       = 8,
  parameter logic [7:0] VEC_BASE = 8'h40,
  parameter logic [7:0] SPUR_VEC = 8'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [5:0]       cfg_wdata,
  input  logic [N_LOC-1:0] loc_irq_i,
  input  logic [N_BP-1:0]  bp_irq_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_IPC-1:0] ipc_sw_i,
  input  logic             iack_i,
  input  logic [2:0]       iack_lvl_i,
  output logic [2:0]       ipl_n_o,
  output logic             vec_vld_o,
  output logic [VW-1:0]    vec_o,
  output logic             vec_ext_o
);

  localparam int BP_OFS  = N_LOC;
  localparam int EVT_OFS = BP_OFS + N_BP;
  localparam int IPC_OFS = EVT_OFS + N_EVT;
  localparam int NSRC    = IPC_OFS + N_IPC;
  localparam int IW      = $clog2(NSRC);

  // ---------------- reset synchronizer
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // ---------------- configuration registers
  loc_cfg_t loc_cfg_q [N_LOC];
  loc_cfg_t loc_cfg_d [N_LOC];
  logic [N_LOC-1:0] loc_wr;
  lvl_t bp_lvl_q, bp_lvl_d, evt_lvl_q, evt_lvl_d, ipc_lvl_q, ipc_lvl_d;

  always_comb begin
    for (int i = 0; i < N_LOC; i++) begin
      loc_wr[i]    = cfg_we && (cfg_addr == 4'(i));
      loc_cfg_d[i] = loc_wr[i] ? loc_cfg_t'(cfg_wdata) : loc_cfg_q[i];
    end
    bp_lvl_d  = (cfg_we && cfg_addr == ADR_BP)  ? cfg_wdata[LVL_W-1:0] : bp_lvl_q;
    evt_lvl_d = (cfg_we && cfg_addr == ADR_EVT) ? cfg_wdata[LVL_W-1:0] : evt_lvl_q;
    ipc_lvl_d = (cfg_we && cfg_addr == ADR_IPC) ? cfg_wdata[LVL_W-1:0] : ipc_lvl_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int i = 0; i < N_LOC; i++) loc_cfg_q[i] <= LOC_CFG_RST;
      bp_lvl_q  <= '0;
      evt_lvl_q <= '0;
      ipc_lvl_q <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_LOC; i++) loc_cfg_q[i] <= loc_cfg_d[i];
      bp_lvl_q  <= bp_lvl_d;
      evt_lvl_q <= evt_lvl_d;
      ipc_lvl_q <= ipc_lvl_d;
    end
  end

  // ---------------- acknowledge selection
  logic [NSRC-1:0]            pend_all;
  logic [NSRC-1:0][LVL_W-1:0] lvl_all;
  logic [NSRC-1:0]            vs_all;
  logic [NSRC-1:0]            clr_vec;
  logic                       ack_hit;
  logic [IW-1:0]              ack_idx;

  irq_lvl_pick #(.N(NSRC), .IW(IW)) u_pick (
    .pend_i (pend_all),
    .lvl_i  (lvl_all),
    .req_i  (iack_lvl_i),
    .hit_o  (ack_hit),
    .idx_o  (ack_idx)
  );

  always_comb begin
    clr_vec = '0;
    if (iack_i && ack_hit) clr_vec[ack_idx] = 1'b1;
  end

  // ---------------- local line conditioners
  logic [N_LOC-1:0] loc_pend;

  for (genvar g = 0; g < N_LOC; g++) begin : g_loc
    irq_src_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_s),
      .in_i      (loc_irq_i[g]),
      .cfg_i     (loc_cfg_q[g]),
      .cfg_wr_i  (loc_wr[g]),
      .ack_clr_i (clr_vec[g]),
      .pend_o    (loc_pend[g])
    );
  end

  // ---------------- status event latches
  logic [N_EVT-1:0] evt_pend_q, evt_pend_d;

  always_comb begin
    evt_pend_d = (evt_pend_q & ~clr_vec[EVT_OFS +: N_EVT]) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) evt_pend_q <= '0;
    else        evt_pend_q <= evt_pend_d;
  end

  // ---------------- source vectors
  always_comb begin
    pend_all = {ipc_sw_i, evt_pend_q, bp_irq_i, loc_pend};
    vs_all   = '0;
    for (int i = 0; i < N_LOC; i++) begin
      lvl_all[i] = loc_cfg_q[i].lvl;
      vs_all[i]  = loc_cfg_q[i].vs;
    end
    for (int i = BP_OFS; i < EVT_OFS; i++)  lvl_all[i] = bp_lvl_q;
    for (int i = EVT_OFS; i < IPC_OFS; i++) lvl_all[i] = evt_lvl_q;
    for (int i = IPC_OFS; i < NSRC; i++)    lvl_all[i] = ipc_lvl_q;
  end

  // ---------------- priority encoding
  lvl_t top_lvl;

  irq_top_enc #(.N(NSRC)) u_enc (
    .pend_i (pend_all),
    .lvl_i  (lvl_all),
    .top_o  (top_lvl)
  );

  // ---------------- output registers
  logic [2:0]    ipl_q, ipl_d;
  logic          vld_q, vld_d;
  logic [VW-1:0] vec_q, vec_d;
  logic          ext_q, ext_d;

  always_comb begin
    ipl_d = ~top_lvl;
    vld_d = iack_i;
    vec_d = SPUR_VEC;
    ext_d = 1'b0;
    if (ack_hit) begin
      if (ack_idx < IW'(BP_OFS)) begin
        if (vs_all[ack_idx]) vec_d = VEC_BASE + VW'(ack_idx);
        else begin
          vec_d = '0;
          ext_d = 1'b1;
        end
      end else if (ack_idx < IW'(EVT_OFS)) begin
        vec_d = '0;
        ext_d = 1'b1;
      end else begin
        vec_d = VEC_BASE + VW'(ack_idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ipl_q <= 3'b111;
      vld_q <= 1'b0;
      vec_q <= '0;
      ext_q <= 1'b0;
    end else begin
      ipl_q <= ipl_d;
      vld_q <= vld_d;
      if (iack_i) begin
        vec_q <= vec_d;
        ext_q <= ext_d;
      end
    end
  end

  assign ipl_n_o   = ipl_q;
  assign vec_vld_o = vld_q;
  assign vec_o     = vec_q;
  assign vec_ext_o = ext_q;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int N_EVT = 6,
  parameter int NSRC  = 28
) (
  input logic             clk,
  input logic             rst_s,
  input logic             iack_i,
  input logic [N_EVT-1:0] evt_i,
  input logic [N_EVT-1:0] evt_pend,
  input logic [NSRC-1:0]  pend,
  input logic [2:0]       ipl_n_o,
  input logic             vec_vld_o
);

  // R2: a non-idle priority code needs a pending source one edge earlier
  a_r2_ipl_needs_pending: assert property (@(posedge clk) disable iff (!rst_s)
    (ipl_n_o != 3'b111) |-> $past(|pend));

  // R9: a response only follows an acknowledge strobe
  a_r9_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_s)
    vec_vld_o |-> $past(iack_i));

  // R7: latched events survive any cycle without an acknowledge
  a_r7_evt_hold: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && !$past(iack_i)) |->
      ((evt_pend & $past(evt_pend)) == $past(evt_pend)));

  // R13: an active event input always leaves its request set
  a_r13_evt_set_wins: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) |-> ((evt_pend & $past(evt_i)) == $past(evt_i)));

endmodule

bind irq_prio_ctl irq_prio_chk #(.N_EVT(N_EVT), .NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .iack_i    (iack_i),
  .evt_i     (evt_i),
  .evt_pend  (evt_pend_q),
  .pend      (pend_all),
  .ipl_n_o   (ipl_n_o),
  .vec_vld_o (vec_vld_o)
);

// File: tb/tb_irq_prio_ctl.sv
module tb_irq_prio_ctl;

  localparam logic [7:0] BASE = 8'h40;
  localparam logic [7:0] SPUR = 8'h18;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [3:0] cfg_addr;
  logic [5:0] cfg_wdata;
  logic [6:0] loc_irq_i;
  logic [6:0] bp_irq_i;
  logic [5:0] evt_i;
  logic [7:0] ipc_sw_i;
  logic       iack_i;
  logic [2:0] iack_lvl_i;
  logic [2:0] ipl_n_o;
  logic       vec_vld_o;
  logic [7:0] vec_o;
  logic       vec_ext_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  irq_prio_ctl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .loc_irq_i(loc_irq_i), .bp_irq_i(bp_irq_i),
    .evt_i(evt_i), .ipc_sw_i(ipc_sw_i), .iack_i(iack_i),
    .iack_lvl_i(iack_lvl_i), .ipl_n_o(ipl_n_o), .vec_vld_o(vec_vld_o),
    .vec_o(vec_o), .vec_ext_o(vec_ext_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [5:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // acknowledge: outputs are checked at the negedge after the strobe edge
  task automatic ack(input logic [2:0] l);
    iack_i = 1'b1; iack_lvl_i = l;
    @(negedge clk);
    iack_i = 1'b0;
  endtask

  task automatic chk_vec(input string req, input int v, input int e);
    chk(req, int'(vec_vld_o), 1);
    chk(req, int'(vec_o), v);
    chk(req, int'(vec_ext_o), e);
  endtask

  task automatic t_reset();
    chk("R1", int'(ipl_n_o), 7);
    chk("R1", int'(vec_vld_o), 0);
  endtask

  task automatic t_level();
    cfg_wr(4'd0, 6'h13);            // level, active high, lvl3, no vector
    cfg_wr(4'd1, 6'h15);            // lvl5
    cfg_wr(4'd2, 6'h10);            // lvl0 masked
    loc_irq_i[0] = 1'b1; step(1);
    chk("R2", int'(ipl_n_o), 4);
    loc_irq_i[1] = 1'b1; step(1);
    chk("R2", int'(ipl_n_o), 2);
    loc_irq_i[1] = 1'b0; loc_irq_i[2] = 1'b1; step(1);
    chk("R2 masked", int'(ipl_n_o), 4);
    ack(3'd3);
    chk_vec("R10 external", 0, 1);
    step(1);
    chk("R5 level kept", int'(ipl_n_o), 4);
    loc_irq_i[0] = 1'b0; loc_irq_i[2] = 1'b0; step(1);
    chk("R5 follows input", int'(ipl_n_o), 7);
    cfg_wr(4'd0, 6'h10); cfg_wr(4'd1, 6'h10);
  endtask

  task automatic t_polarity();
    cfg_wr(4'd3, 6'h04);            // active low, lvl4
    step(1);
    chk("R3 active low", int'(ipl_n_o), 3);
    loc_irq_i[3] = 1'b1; step(1);
    chk("R3 inactive high", int'(ipl_n_o), 7);
    loc_irq_i[3] = 1'b0;
    cfg_wr(4'd3, 6'h10); step(1);
  endtask

  task automatic t_edge();
    cfg_wr(4'd4, 6'h3E);            // vector, rising, edge, lvl6
    loc_irq_i[4] = 1'b1; step(1);
    loc_irq_i[4] = 1'b0; step(1);
    chk("R4 latched", int'(ipl_n_o), 1);
    step(3);
    chk("R4 held", int'(ipl_n_o), 1);
    ack(3'd6);
    chk_vec("R10 own vector", int'(BASE) + 4, 0);
    step(1);
    chk("R4 cleared", int'(ipl_n_o), 7);
    cfg_wr(4'd4, 6'h10);
    // falling edge
    loc_irq_i[5] = 1'b1; step(1);
    cfg_wr(4'd5, 6'h0A);            // falling, edge, lvl2
    step(2);
    chk("R3 no edge yet", int'(ipl_n_o), 7);
    loc_irq_i[5] = 1'b0; step(2);
    chk("R3 falling latched", int'(ipl_n_o), 5);
    cfg_wr(4'd5, 6'h0A); step(1);
    chk("R12 cfg clears", int'(ipl_n_o), 7);
    cfg_wr(4'd5, 6'h10); step(1);
  endtask

  task automatic t_bp_ipc();
    cfg_wr(4'd8, 6'd5);
    cfg_wr(4'd10, 6'd5);
    bp_irq_i[2] = 1'b1; ipc_sw_i[1] = 1'b1; step(1);
    chk("R6", int'(ipl_n_o), 2);
    ack(3'd5);
    chk_vec("R6 R9 tie", 0, 1);
    bp_irq_i[2] = 1'b0; step(1);
    ack(3'd5);
    chk_vec("R8", int'(BASE) + 21, 0);
    ipc_sw_i[1] = 1'b0;
    cfg_wr(4'd8, 6'd0); cfg_wr(4'd10, 6'd0); step(1);
    chk("R8 released", int'(ipl_n_o), 7);
  endtask

  task automatic t_events();
    cfg_wr(4'd9, 6'd7);
    evt_i[3] = 1'b1; evt_i[1] = 1'b1; step(1);
    evt_i = '0; step(1);
    chk("R7 latched", int'(ipl_n_o), 0);
    step(3);
    chk("R7 held", int'(ipl_n_o), 0);
    ack(3'd7);
    chk_vec("R7 R9 lowest first", int'(BASE) + 15, 0);
    step(1);
    chk("R7 other kept", int'(ipl_n_o), 0);
    ack(3'd7);
    chk_vec("R7", int'(BASE) + 17, 0);
    step(1);
    chk("R7 all cleared", int'(ipl_n_o), 7);
  endtask

  task automatic t_set_wins();
    evt_i[0] = 1'b1; step(1);
    evt_i[0] = 1'b0; step(1);
    chk("R13 latched", int'(ipl_n_o), 0);
    iack_i = 1'b1; iack_lvl_i = 3'd7; evt_i[0] = 1'b1;
    @(negedge clk);
    iack_i = 1'b0; evt_i[0] = 1'b0;
    chk_vec("R13", int'(BASE) + 14, 0);
    step(1);
    chk("R13 still pending", int'(ipl_n_o), 0);
    ack(3'd7);
    chk_vec("R13 second ack", int'(BASE) + 14, 0);
    step(1);
    chk("R13 cleared", int'(ipl_n_o), 7);
    cfg_wr(4'd9, 6'd0);
  endtask

  task automatic t_spurious();
    ack(3'd1);
    chk_vec("R11", int'(SPUR), 0);
    step(1);
    chk("R9 one cycle", int'(vec_vld_o), 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    loc_irq_i = '0; bp_irq_i = '0; evt_i = '0; ipc_sw_i = '0;
    iack_i = 1'b0; iack_lvl_i = '0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_level();
    t_polarity();
    t_edge();
    t_bp_ipc();
    t_events();
    t_set_wins();
    t_spurious();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule